// File: doc/BRIEF.md
# Backward Metric Recursion and Bit Reliability Unit

This block is the reverse half of a max-log soft-in soft-out decoder for the eight-state recursive systematic convolutional code with feedback 1+D^2+D^3 and feed-forward 1+D+D^3. It walks a frame from its last trellis step down to step 0 and accepts one step per clock. For each step it takes the channel systematic and parity values, the a-priori value and the eight forward state metrics saved by the forward pass. From these it forms the bit reliability (log-likelihood ratio) of that step's information bit and the extrinsic value that goes to the other component decoder.

The backward state metrics are never written out. The unit holds only the current eight-entry vector and updates it in place. The bit-1 and bit-0 candidates of each state are formed before the survivor selection, and they are the ones added to the forward metrics to build the reliability. Two pipelined eight-input comparator trees reduce the sums. A selectable output mode also removes the systematic value from the extrinsic output. This lets the second decoder in an iterative loop skip a separate systematic interleaver. Channel values are used as received, with no scaling.

Top module: `bwd_llr_unit`

## Requirements
- R1: While `rst` is high and after its release, until the first result arrives, `out_valid` is 0 and `out_llr`, `out_ext` and `out_idx` are 0.
- R2: A step presented with `in_first` high starts a new frame. Its backward metrics are taken as 0 for state 0 and -128 for states 1 to 7, and the metrics held from earlier steps are ignored.
- R3: State s has bits r1=s[2], r2=s[1], r3=s[0]. For input bit u: feedback a = u^r2^r3, parity c = a^r1^r3, and next state = {a, r1, r2}. The branch value of an edge is u*(sys+apr) + c*par, with u and c taken as 0 or 1.
- R4: For state s, cand_u(s) = beta_next(next(s,u)) + branch(s,u). The reliability is max over s of (alpha(s)+cand_1(s)) minus max over s of (alpha(s)+cand_0(s)). alpha(s) is `in_alpha[s*14 +: 14]` (two's complement).
- R5: After each accepted step, the held backward metric of state s becomes max(cand_1(s), cand_0(s)) up to a common offset, and the next accepted step of the same frame uses it.
- R6: With `in_second` low, the extrinsic value is reliability minus apr.
- R7: With `in_second` high, the extrinsic value is reliability minus apr minus sys.
- R8: `out_llr` and `out_ext` are the full-precision values clipped to [-128, 127]. The extrinsic value is formed from the unclipped reliability.
- R9: `out_idx` is `in_len`-1 for the frame's first step and one less for each following step.
- R10: One step is accepted per cycle with `in_valid` high. Its result appears with `out_valid` exactly 5 clock edges after the edge that samples it, in input order. Cycles with `in_valid` low leave all held state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Step present this cycle |
| in_first | input | 1 | Step is the last trellis step of a new frame |
| in_len | input | 10 | Frame length, sampled with in_first |
| in_second | input | 1 | Extrinsic mode: 1 also removes systematic value |
| in_sys | input | 8 | Systematic channel value, signed |
| in_par | input | 8 | Parity channel value, signed |
| in_apr | input | 8 | A-priori value, signed |
| in_alpha | input | 112 | Eight forward metrics, 14-bit signed each, state s at bits s*14 |
| out_valid | output | 1 | Result present |
| out_llr | output | 8 | Clipped bit reliability, signed |
| out_ext | output | 8 | Clipped extrinsic value, signed |
| out_idx | output | 10 | Trellis step index of the result |

## Verification
On every cycle the assertions check four things: each comparator node is no smaller than either child, large differences clip to the output limits, result indices descend by one within a frame, and the valid flag follows the input valid five edges later. They also check that the held metrics stay inside their headroom. Only the bench scenarios can show that the reliability and extrinsic values are numerically right across frame starts, long recursions, idle gaps carrying garbage inputs, and both extrinsic modes. That needs a full trellis model of the recursion.

// File: rtl/bwd_llr_pkg.sv
package bwd_llr_pkg;
  localparam int MEM = 3;
  localparam int NS  = 1 << MEM;

  typedef logic [MEM-1:0] st_t;

  // next state for input bit u: {feedback, r1, r2}
  function automatic st_t nxt_state(input st_t s, input logic u);
    logic fb;
    fb = u ^ s[1] ^ s[0];
    return {fb, s[2], s[1]};
  endfunction

  // parity bit produced on the edge leaving s with input u
  function automatic logic edge_par(input st_t s, input logic u);
    return u ^ s[2] ^ s[1];
  endfunction
endpackage

// File: rtl/bwd_acs.sv
module bwd_acs import bwd_llr_pkg::*; #(
  parameter  int MW = 14,
  parameter  int GW = 10,
  localparam int CW = MW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_en,
  input  logic                 first,
  input  logic signed [GW-1:0] lsum,
  input  logic signed [GW-1:0] par,
  output logic signed [CW-1:0] cand1 [NS],
  output logic signed [CW-1:0] cand0 [NS]
);
  localparam logic signed [MW-1:0] INIT_LO = MW'(-128);
  localparam logic signed [MW-1:0] ZERO_M  = '0;
  localparam logic signed [GW-1:0] ZERO_G  = '0;
  localparam logic signed [MW-1:0] HEAD    = MW'(1 << (MW - 2));

  logic signed [MW-1:0] beta_q [NS];
  logic signed [MW-1:0] src    [NS];
  logic signed [GW-1:0] g1     [NS];
  logic signed [GW-1:0] g0     [NS];
  logic signed [CW-1:0] win    [NS];
  logic signed [MW-1:0] beta_d [NS];

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      if (first) src[s] = (s == 0) ? ZERO_M : INIT_LO;
      else       src[s] = beta_q[s];
    end
    for (int s = 0; s < NS; s++) begin
      g1[s]    = lsum + (edge_par(st_t'(s), 1'b1) ? par : ZERO_G);
      g0[s]    = edge_par(st_t'(s), 1'b0) ? par : ZERO_G;
      cand1[s] = CW'(src[nxt_state(st_t'(s), 1'b1)]) + CW'(g1[s]);
      cand0[s] = CW'(src[nxt_state(st_t'(s), 1'b0)]) + CW'(g0[s]);
      win[s]   = (cand1[s] > cand0[s]) ? cand1[s] : cand0[s];
    end
    for (int s = 0; s < NS; s++) begin
      beta_d[s] = MW'(win[s] - win[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) beta_q[s] <= (s == 0) ? ZERO_M : INIT_LO;
    end else if (step_en) begin
      for (int s = 0; s < NS; s++) beta_q[s] <= beta_d[s];
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_chk
    // R5
    metric_headroom_chk: assert property (@(posedge clk) disable iff (rst)
      (beta_q[s] < HEAD) && (beta_q[s] > -HEAD));
  end
endmodule

// File: rtl/bwd_max_tree.sv
module bwd_max_tree #(
  parameter  int W  = 16,
  parameter  int N  = 8,
  localparam int LV = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_in,
  input  logic signed [W-1:0] d_in [N],
  output logic                v_out,
  output logic signed [W-1:0] d_out
);
  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int CNT = N >> l;
    logic signed [W-1:0] q [CNT];
    logic                v;
    if (l == 0) begin : g_root
      assign q = d_in;
      assign v = v_in;
    end else begin : g_node
      always_ff @(posedge clk) begin
        if (rst) v <= 1'b0;
        else     v <= g_lv[l-1].v;
        for (int j = 0; j < CNT; j++) begin
          q[j] <= (g_lv[l-1].q[2*j] >= g_lv[l-1].q[2*j+1]) ?
                  g_lv[l-1].q[2*j] : g_lv[l-1].q[2*j+1];
        end
      end
      for (genvar j = 0; j < CNT; j++) begin : g_a
        // R4
        tree_pick_chk: assert property (@(posedge clk) disable iff (rst)
          v |-> (q[j] >= $past(g_lv[l-1].q[2*j])) &&
                (q[j] >= $past(g_lv[l-1].q[2*j+1])));
      end
    end
  end

  assign v_out = g_lv[LV].v;
  assign d_out = g_lv[LV].q[0];
endmodule

// File: rtl/bwd_out_stage.sv
module bwd_out_stage #(
  parameter  int W    = 16,
  parameter  int IN_W = 8,
  parameter  int OW   = 8,
  parameter  int TW   = 11,
  localparam int DW   = W + 1,
  localparam int EW   = W + 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   v_in,
  input  logic signed [W-1:0]    mx1,
  input  logic signed [W-1:0]    mx0,
  input  logic signed [IN_W-1:0] apr,
  input  logic signed [IN_W-1:0] sys,
  input  logic                   second,
  input  logic [TW-1:0]          tag_in,
  output logic                   v_out,
  output logic signed [OW-1:0]   llr_o,
  output logic signed [OW-1:0]   ext_o,
  output logic [TW-1:0]          tag_o
);
  localparam logic signed [OW-1:0] OMAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] OMIN = {1'b1, {(OW-1){1'b0}}};
  localparam logic signed [EW-1:0] ZE   = '0;

  logic signed [DW-1:0] diff;
  logic signed [EW-1:0] ext_full;

  function automatic logic signed [OW-1:0] clip(input logic signed [EW-1:0] x);
    if (x > EW'(OMAX))      return OMAX;
    else if (x < EW'(OMIN)) return OMIN;
    else                    return OW'(x);
  endfunction

  assign diff     = DW'(mx1) - DW'(mx0);
  assign ext_full = EW'(diff) - EW'(apr) - (second ? EW'(sys) : ZE);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      llr_o <= '0;
      ext_o <= '0;
      tag_o <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        llr_o <= clip(EW'(diff));
        ext_o <= clip(ext_full);
        tag_o <= tag_in;
      end
    end
  end

  // R8
  llr_clip_hi_chk: assert property (@(posedge clk) disable iff (rst)
    v_in && (diff > DW'(OMAX)) |=> llr_o == OMAX);
  // R8
  llr_clip_lo_chk: assert property (@(posedge clk) disable iff (rst)
    v_in && (diff < DW'(OMIN)) |=> llr_o == OMIN);
endmodule

// File: rtl/bwd_llr_unit.sv
module bwd_llr_unit import bwd_llr_pkg::*; #(
  parameter  int IN_W = 8,
  parameter  int MW   = 14,
  parameter  int OW   = 8,
  parameter  int IW   = 10,
  localparam int GW   = IN_W + 2,
  localparam int CW   = MW + 1,
  localparam int SW   = MW + 2,
  localparam int LV   = $clog2(NS),
  localparam int TW   = IW + 1,
  localparam int SBW  = 2 * IN_W + 1 + TW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_first,
  input  logic [IW-1:0]          in_len,
  input  logic                   in_second,
  input  logic signed [IN_W-1:0] in_sys,
  input  logic signed [IN_W-1:0] in_par,
  input  logic signed [IN_W-1:0] in_apr,
  input  logic [NS*MW-1:0]       in_alpha,
  output logic                   out_valid,
  output logic signed [OW-1:0]   out_llr,
  output logic signed [OW-1:0]   out_ext,
  output logic [IW-1:0]          out_idx
);
  // step index counter
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_cur;
  assign idx_cur = in_first ? in_len - IW'(1) : idx_q - IW'(1);

  always_ff @(posedge clk) begin
    if (rst)           idx_q <= '0;
    else if (in_valid) idx_q <= idx_cur;
  end

  // branch inputs
  logic signed [GW-1:0] lsum;
  logic signed [GW-1:0] parx;
  assign lsum = GW'(in_sys) + GW'(in_apr);
  assign parx = GW'(in_par);

  logic signed [CW-1:0] cand1 [NS];
  logic signed [CW-1:0] cand0 [NS];

  bwd_acs #(.MW(MW), .GW(GW)) u_acs (
    .clk     (clk),
    .rst     (rst),
    .step_en (in_valid),
    .first   (in_first),
    .lsum    (lsum),
    .par     (parx),
    .cand1   (cand1),
    .cand0   (cand0)
  );

  // candidate plus forward metric
  logic signed [SW-1:0] sum1 [NS];
  logic signed [SW-1:0] sum0 [NS];
  logic                 sum_v;
  logic [SBW-1:0]       sb0;

  always_ff @(posedge clk) begin
    if (rst) sum_v <= 1'b0;
    else     sum_v <= in_valid;
    if (in_valid) begin
      for (int s = 0; s < NS; s++) begin
        sum1[s] <= SW'($signed(in_alpha[s*MW +: MW])) + SW'(cand1[s]);
        sum0[s] <= SW'($signed(in_alpha[s*MW +: MW])) + SW'(cand0[s]);
      end
      sb0 <= {in_second, in_sys, in_apr, in_first, idx_cur};
    end
  end

  // side-band delay matched to the comparator trees
  logic [SBW-1:0] sb_pipe [LV];
  always_ff @(posedge clk) begin
    sb_pipe[0] <= sb0;
    for (int k = 1; k < LV; k++) sb_pipe[k] <= sb_pipe[k-1];
  end

  logic                   sb_second;
  logic signed [IN_W-1:0] sb_sys;
  logic signed [IN_W-1:0] sb_apr;
  logic [TW-1:0]          sb_tag;
  assign sb_second = sb_pipe[LV-1][SBW-1];
  assign sb_sys    = sb_pipe[LV-1][SBW-2 -: IN_W];
  assign sb_apr    = sb_pipe[LV-1][SBW-2-IN_W -: IN_W];
  assign sb_tag    = sb_pipe[LV-1][TW-1:0];

  logic                 v1, v0;
  logic signed [SW-1:0] mx1, mx0;

  bwd_max_tree #(.W(SW), .N(NS)) u_max1 (
    .clk (clk), .rst (rst), .v_in (sum_v), .d_in (sum1), .v_out (v1), .d_out (mx1)
  );
  bwd_max_tree #(.W(SW), .N(NS)) u_max0 (
    .clk (clk), .rst (rst), .v_in (sum_v), .d_in (sum0), .v_out (v0), .d_out (mx0)
  );

  logic [TW-1:0] tag_o;
  logic          out_first;

  bwd_out_stage #(.W(SW), .IN_W(IN_W), .OW(OW), .TW(TW)) u_out (
    .clk    (clk),
    .rst    (rst),
    .v_in   (v1 & v0),
    .mx1    (mx1),
    .mx0    (mx0),
    .apr    (sb_apr),
    .sys    (sb_sys),
    .second (sb_second),
    .tag_in (sb_tag),
    .v_out  (out_valid),
    .llr_o  (out_llr),
    .ext_o  (out_ext),
    .tag_o  (tag_o)
  );

  assign out_first = tag_o[TW-1];
  assign out_idx   = tag_o[IW-1:0];

  // checker state
  logic [IW-1:0] last_idx;
  logic          seen;
  logic [2:0]    age;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_idx <= '0;
      seen     <= 1'b0;
      age      <= '0;
    end else begin
      if (age != 3'd7) age <= age + 3'd1;
      if (out_valid) begin
        seen     <= 1'b1;
        last_idx <= out_idx;
      end
    end
  end

  // R9
  idx_descend_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_first && seen |-> out_idx == last_idx - IW'(1));
  // R10
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 3'd7) |-> out_valid == $past(in_valid, LV + 2));
endmodule

// File: tb/bwd_llr_unit_bench.sv
module bwd_llr_unit_bench;
  localparam int IN_W = 8;
  localparam int MW   = 14;
  localparam int OW   = 8;
  localparam int IW   = 10;
  localparam int NS   = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                   rst;
  logic                   in_valid, in_first, in_second;
  logic [IW-1:0]          in_len;
  logic signed [IN_W-1:0] in_sys, in_par, in_apr;
  logic [NS*MW-1:0]       in_alpha;
  logic                   out_valid;
  logic signed [OW-1:0]   out_llr, out_ext;
  logic [IW-1:0]          out_idx;

  bwd_llr_unit #(.IN_W(IN_W), .MW(MW), .OW(OW), .IW(IW)) u_bwd_llr_unit (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_first (in_first),
    .in_len (in_len), .in_second (in_second), .in_sys (in_sys), .in_par (in_par),
    .in_apr (in_apr), .in_alpha (in_alpha), .out_valid (out_valid),
    .out_llr (out_llr), .out_ext (out_ext), .out_idx (out_idx)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int llr; int ext; int idx; int cyc;
    bit first; bit second; bit sl; bit se;
  } exp_t;
  exp_t eq [$];
  exp_t e;

  int mb [NS];
  int cur_idx;

  function automatic int nx(int s, int u);
    int fb;
    fb = u ^ ((s >> 1) & 1) ^ (s & 1);
    return (fb << 2) | ((s >> 1) & 3);
  endfunction

  function automatic int pb(int s, int u);
    return u ^ ((s >> 2) & 1) ^ ((s >> 1) & 1);
  endfunction

  function automatic int sat(int x);
    if (x > 127)  return 127;
    if (x < -128) return -128;
    return x;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(bit first, int len, bit second, int sys, int par, int apr, int amax);
    int a [NS];
    int nb [NS];
    int L, c1, c0, m1, m0, llr, ext;
    exp_t x;
    for (int s = 0; s < NS; s++) begin
      a[s] = (amax == 0) ? 0 : $urandom_range(0, 2 * amax) - amax;
      in_alpha[s*MW +: MW] = MW'(a[s]);
    end
    in_valid  = 1'b1;
    in_first  = first;
    in_len    = IW'(len);
    in_second = second;
    in_sys    = IN_W'(sys);
    in_par    = IN_W'(par);
    in_apr    = IN_W'(apr);
    if (first) begin
      for (int s = 0; s < NS; s++) mb[s] = (s == 0) ? 0 : -128;
      cur_idx = len - 1;
    end else begin
      cur_idx = cur_idx - 1;
    end
    L  = sys + apr;
    m1 = -(1 << 30);
    m0 = -(1 << 30);
    for (int s = 0; s < NS; s++) begin
      c1 = mb[nx(s, 1)] + L + ((pb(s, 1) != 0) ? par : 0);
      c0 = mb[nx(s, 0)] + ((pb(s, 0) != 0) ? par : 0);
      if (a[s] + c1 > m1) m1 = a[s] + c1;
      if (a[s] + c0 > m0) m0 = a[s] + c0;
      nb[s] = (c1 > c0) ? c1 : c0;
    end
    for (int s = 0; s < NS; s++) mb[s] = nb[s];
    llr = m1 - m0;
    ext = second ? llr - apr - sys : llr - apr;
    x.llr = sat(llr); x.ext = sat(ext); x.idx = cur_idx & ((1 << IW) - 1);
    x.cyc = cyc + 5; x.first = first; x.second = second;
    x.sl = (sat(llr) != llr); x.se = (sat(ext) != ext);
    eq.push_back(x);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      in_valid  = 1'b0;
      in_first  = 1'($urandom_range(0, 1));
      in_len    = IW'($urandom_range(1, 900));
      in_second = 1'($urandom_range(0, 1));
      in_sys    = IN_W'($urandom);
      in_par    = IN_W'($urandom);
      in_apr    = IN_W'($urandom);
      for (int s = 0; s < NS; s++) in_alpha[s*MW +: MW] = MW'($urandom_range(0, 1200) - 600);
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (eq.size() == 0) begin
        chk("R10 unexpected result", 1, 0);
      end else begin
        string tl, te;
        e  = eq.pop_front();
        tl = e.first ? "R2 R3 R4 llr" : "R3 R4 R5 llr";
        if (e.sl) tl = {tl, " R8"};
        te = e.second ? "R7 ext" : "R6 ext";
        if (e.se) te = {te, " R8"};
        chk(tl, int'(out_llr), e.llr);
        chk(te, int'(out_ext), e.ext);
        chk("R9 idx", int'(out_idx), e.idx);
        chk("R10 latency", cyc, e.cyc);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    rst = 1'b1; in_valid = 0; in_first = 0; in_second = 0; in_len = '0;
    in_sys = '0; in_par = '0; in_apr = '0; in_alpha = '0;
    repeat (4) @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 llr", int'(out_llr), 0);
    chk("R1 ext", int'(out_ext), 0);
    chk("R1 idx", int'(out_idx), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after release", int'(out_valid), 0);

    // single-step frame, all zero
    drive(1, 1, 0, 0, 0, 0, 0);
    // strong positive values, clipping high (R8)
    drive(1, 3, 0, 127, 127, 127, 0);
    drive(0, 3, 0, 127, 127, 127, 0);
    drive(0, 3, 1, 127, -128, 127, 0);
    // strong negative values, clipping low (R8)
    drive(1, 2, 1, -128, -128, -128, 0);
    drive(0, 2, 1, -128, -128, -128, 0);
    idle(3);
    // small directed frame with gaps carrying garbage (R10)
    drive(1, 4, 0, 10, -7, 3, 20);
    idle(2);
    drive(0, 4, 0, -5, 9, -2, 20);
    idle(1);
    drive(0, 4, 0, 4, 4, 4, 20);
    drive(0, 4, 0, -12, 6, 1, 20);

    // random frames, back-to-back and with gaps
    for (int f = 0; f < 40; f++) begin
      int len;
      bit sec;
      bit big;
      len = $urandom_range(1, 48);
      sec = f[0];
      big = ($urandom_range(0, 2) == 0);
      for (int k = 0; k < len; k++) begin
        if (big)
          drive(k == 0, len, sec, $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
                $urandom_range(0, 255) - 128, 600);
        else
          drive(k == 0, len, sec, $urandom_range(0, 40) - 20, $urandom_range(0, 40) - 20,
                $urandom_range(0, 40) - 20, 30);
        if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
      end
    end
    idle(10);
    chk("R10 drained", eq.size(), 0);
    summary();
    $finish;
  end
endmodule